// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block is the hazard controller of a five-stage in-order pipeline whose stages are, in order: fetch, decode with register read, execute, memory access, and writeback. It looks at the source register numbers of the instruction in execute. It compares them with the destination numbers held in the two later pipeline registers, which sit between execute and memory and between memory and writeback. From those comparisons it picks, for each ALU operand, whether the value comes from the register file or is bypassed from one of the later stages.

One kind of dependency cannot be bypassed: an instruction in decode that needs the result of a load currently in execute. For that case the block asserts a hold for the program counter and the fetch/decode register, and a flush that loads a bubble into the decode/execute register. The load then moves ahead by one stage. On the next cycle the consumer in decode no longer matches anything in execute, so the hold drops. One cycle later the consumer takes the loaded value through the writeback bypass.

The register file is written early in a cycle and read late, so a writeback and a decode of the same register need no bypass and no hold. The block is purely combinational. The clock and reset serve only its embedded assertions.

Top module: `hz_unit`

## Requirements
- R1: Operand select encoding: `fwd_a` (for `ex_rs`) and `fwd_b` (for `ex_rt`) are 2'b10 when the execute/memory register writes that register, 2'b01 when only the memory/writeback register writes it, and 2'b00 (register file) otherwise.
- R2: When both later stages write the same source register, the execute/memory stage wins and the select is 2'b10.
- R3: A producer whose destination is register 0, or whose write enable is low, causes neither a bypass nor a hold. This applies with the default `R0_HARDWIRED = 1`.
- R4: `hold_front` and `flush_idex` are both 1 exactly when the decode/execute register holds a load (`ex_mrd = 1`, `ex_wen = 1`, nonzero `ex_rd`) whose destination equals `id_rs` or `id_rt`.
- R5: A producer in execute that is not a load never causes a hold, even when its destination matches a decode source.
- R6: After a one-cycle hold, the consumer in decode no longer triggers a hold once the bubble has entered execute. When the consumer reaches execute, the load's result is selected from memory/writeback (2'b01).
- R7: A writeback destination equal to a decode source causes no hold.
- R8: The value 2'b11 never appears on `fwd_a` or `fwd_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the assertions only |
| rst_n | input | 1 | Active-low reset, disables the assertions |
| id_rs | input | REG_W | First source register of the instruction in decode |
| id_rt | input | REG_W | Second source register of the instruction in decode |
| ex_rs | input | REG_W | First source register of the instruction in execute |
| ex_rt | input | REG_W | Second source register of the instruction in execute |
| ex_rd | input | REG_W | Destination held in the decode/execute register |
| ex_wen | input | 1 | Register write enable of the instruction in execute |
| ex_mrd | input | 1 | Instruction in execute reads data memory (load) |
| mem_rd | input | REG_W | Destination held in the execute/memory register |
| mem_wen | input | 1 | Register write enable of the instruction in memory |
| wb_rd | input | REG_W | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Register write enable of the instruction in writeback |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| hold_front | output | 1 | Keep PC and fetch/decode register unchanged |
| flush_idex | output | 1 | Load a bubble with all write enables cleared into decode/execute |

## Verification
The bench builds the unit with `REG_W = 3`, a register space of eight, with register 0 hardwired. At that size it can step through every combination of execute source, memory destination, writeback destination and both write enables. It can likewise step through every decode source pair against every execute destination, write enable and load flag. This covers every priority case, every zero-register case and every partial-match case, with expected selects worked out arithmetically. A short hand-built sequence, a load followed by a dependent add, shows that the hold lasts one cycle and that the writeback bypass follows.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_WB      = 2'b01,
      SRC_MEM     = 2'b10
   } src_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
   parameter int REG_W        = 5,
   parameter bit R0_HARDWIRED = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   generate
      if (R0_HARDWIRED) begin : g_r0_const
         always_comb hit = wen && (dst != ZERO_REG) && (src == dst);
      end else begin : g_r0_plain
         always_comb hit = wen && (src == dst);
      end
   endgenerate
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
   import hz_pkg::*;
#(
   parameter int REG_W        = 5,
   parameter bit R0_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output src_sel_e         sel
);
   logic hit_mem, hit_wb;

   hz_match #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_match_mem (
      .src(src), .dst(mem_rd), .wen(mem_wen), .hit(hit_mem)
   );
   hz_match #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_match_wb (
      .src(src), .dst(wb_rd), .wen(wb_wen), .hit(hit_wb)
   );

   always_comb begin
      if (hit_mem)     sel = SRC_MEM;
      else if (hit_wb) sel = SRC_WB;
      else             sel = SRC_REGFILE;
   end

   // R2: the younger producer must win over the older one
   p_mem_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && mem_rd == src && mem_rd != '0) |-> (sel == SRC_MEM));
   // R3: a disabled older producer never feeds the operand
   p_wb_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_WB) |-> (wb_wen && wb_rd == src));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_W        = 5,
   parameter bit R0_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_mrd,
   output logic             stall
);
   logic load_wr;
   logic hit_rs, hit_rt;

   always_comb load_wr = ex_wen && ex_mrd;

   hz_match #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_match_rs (
      .src(id_rs), .dst(ex_rd), .wen(load_wr), .hit(hit_rs)
   );
   hz_match #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_match_rt (
      .src(id_rt), .dst(ex_rd), .wen(load_wr), .hit(hit_rt)
   );

   always_comb stall = hit_rs || hit_rt;

   // R5: only a load in execute may cause an interlock
   p_load_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_mrd && ex_wen));
   // R4: a matching load always interlocks
   p_match_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_mrd && ex_wen && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt)) |-> stall);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
   import hz_pkg::*;
#(
   parameter int REG_W        = 5,
   parameter bit R0_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic [REG_W-1:0] ex_rs,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_mrd,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b,
   output logic             hold_front,
   output logic             flush_idex
);
   localparam int N_OPND = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("hz_unit: REG_W must lie in 1..8");
      end
   endgenerate

   logic [REG_W-1:0] opnd_src [N_OPND];
   src_sel_e         opnd_sel [N_OPND];
   logic             stall;

   always_comb begin
      opnd_src[0] = ex_rs;
      opnd_src[1] = ex_rt;
   end

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         hz_fwd_sel #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_sel (
            .clk(clk), .rst_n(rst_n), .src(opnd_src[g]),
            .mem_rd(mem_rd), .mem_wen(mem_wen),
            .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(opnd_sel[g])
         );
      end
   endgenerate

   hz_load_use #(.REG_W(REG_W), .R0_HARDWIRED(R0_HARDWIRED)) i_load_use (
      .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mrd(ex_mrd), .stall(stall)
   );

   always_comb begin
      fwd_a      = opnd_sel[0];
      fwd_b      = opnd_sel[1];
      hold_front = stall;
      flush_idex = stall;
   end

   // R8: illegal select code never leaves the block
   p_sel_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'b11) && (fwd_b != 2'b11));
   // R4: hold and bubble always travel together
   p_hold_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_front == flush_idex);
   // R3: register 0 is never bypassed
   p_zero_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (R0_HARDWIRED && ex_rs == '0) |-> (fwd_a == 2'b00));
   // R7: a writeback-only producer never interlocks decode
   p_wb_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_wen) |-> !hold_front);
endmodule

// File: tb/test_hz_unit.sv
module test_hz_unit;
   localparam int W = 3;
   localparam int NR = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
   logic ex_wen, ex_mrd, mem_wen, wb_wen;
   logic [1:0] fwd_a, fwd_b;
   logic hold_front, flush_idex;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hz_unit #(.REG_W(W), .R0_HARDWIRED(1'b1)) i_hz_unit (
      .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
      .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen),
      .ex_mrd(ex_mrd), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .wb_rd(wb_rd), .wb_wen(wb_wen), .fwd_a(fwd_a), .fwd_b(fwd_b),
      .hold_front(hold_front), .flush_idex(flush_idex)
   );

   function automatic logic [1:0] exp_sel(int src, int mrd, bit mw, int wrd, bit ww);
      if (mw && mrd != 0 && mrd == src) return 2'b10;
      if (ww && wrd != 0 && wrd == src) return 2'b01;
      return 2'b00;
   endfunction

   task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      id_rs = '0; id_rt = '0; ex_rs = '0; ex_rt = '0; ex_rd = '0;
      mem_rd = '0; wb_rd = '0;
      ex_wen = 0; ex_mrd = 0; mem_wen = 0; wb_wen = 0;
   endtask

   initial begin
      clear_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R3 reset state: all-zero inputs give no bypass, no hold
      chk("R3", fwd_a, 2'b00);
      chk("R3", fwd_b, 2'b00);
      chk("R4", {hold_front, flush_idex}, 2'b00);

      // R1 R2 R3 R8: full sweep of bypass selection
      for (int s = 0; s < NR; s++)
         for (int m = 0; m < NR; m++)
            for (int w = 0; w < NR; w++)
               for (int e = 0; e < 4; e++) begin
                  @(negedge clk);
                  ex_rs = W'(s); ex_rt = W'((s + 3) % NR);
                  mem_rd = W'(m); wb_rd = W'(w);
                  mem_wen = e[0]; wb_wen = e[1];
                  #1;
                  chk("R1/R2/R3 fwd_a", fwd_a, exp_sel(s, m, e[0], w, e[1]));
                  chk("R1/R2/R3 fwd_b", fwd_b, exp_sel((s + 3) % NR, m, e[0], w, e[1]));
                  if (fwd_a == 2'b11 || fwd_b == 2'b11) chk("R8", 2'b11, 2'b00);
               end
      clear_inputs();

      // R4 R5 R7: full sweep of interlock detection
      for (int a = 0; a < NR; a++)
         for (int b = 0; b < NR; b++)
            for (int d = 0; d < NR; d++)
               for (int e = 0; e < 4; e++) begin
                  bit exp_h;
                  @(negedge clk);
                  id_rs = W'(a); id_rt = W'(b); ex_rd = W'(d);
                  ex_wen = e[0]; ex_mrd = e[1];
                  wb_rd = W'(a); wb_wen = 1'b1; // R7: writeback match must not hold
                  #1;
                  exp_h = e[0] && e[1] && d != 0 && (d == a || d == b);
                  chk(exp_h ? "R4 hold" : "R5/R7 no hold", {1'b0, hold_front}, {1'b0, exp_h});
                  chk("R4 flush", {1'b0, flush_idex}, {1'b0, exp_h});
               end
      clear_inputs();

      // R6: load r2 then add r3,r1,r2
      @(negedge clk);
      ex_rd = 3'd2; ex_wen = 1; ex_mrd = 1;
      id_rs = 3'd1; id_rt = 3'd2;
      #1; chk("R6 stall cycle", {1'b0, hold_front}, 2'b01);
      @(negedge clk); // bubble in execute, load in memory
      ex_rd = '0; ex_wen = 0; ex_mrd = 0;
      mem_rd = 3'd2; mem_wen = 1;
      #1; chk("R6 single stall", {1'b0, hold_front}, 2'b00);
      @(negedge clk); // add in execute, load in writeback
      ex_rs = 3'd1; ex_rt = 3'd2; ex_rd = 3'd3; ex_wen = 1;
      mem_rd = '0; mem_wen = 0;
      wb_rd = 3'd2; wb_wen = 1;
      id_rs = '0; id_rt = '0;
      #1;
      chk("R6 wb bypass b", fwd_b, 2'b01);
      chk("R6 fwd_a", fwd_a, 2'b00);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule